// File: doc/BRIEF.md
# Power-on configuration bank loader

This sequencer runs once every time the supply-valid reset is released. It holds the conditioned output disabled while a settling delay runs, then consults a small set of write-once bank-select slots in a nonvolatile array to decide which of several stored configuration banks should be used. It reads that bank word by word, staging each word internally and summing them as it goes. Only when the bank's sum checks out does it copy the staged words into the working register file and enable the output; otherwise the output stays off and an error flag is raised.

The slots can each be written once, in rising order, so the boot bank can be changed a limited number of times. The loader honours the most recently written slot by scanning from the highest slot downwards. An instant-on input shortens the settling delay to a single cycle for systems that need the output quickly. Because reset is re-applied whenever the supply drops, any brown-out simply restarts the whole sequence.

Top module: `cfg_boot_loader`

## Requirements
- R1: While reset is held and in the first cycle after it, out_en, done, load_err, wr_en and nv_rd_en are all low.
- R2: With instant_on low, the first storage read (nv_rd_en high) occurs exactly SETTLE_CYCLES clock edges after reset release, and out_en stays low until done.
- R3: With instant_on high, the first storage read occurs on the first clock edge after reset release.
- R4: Slots sit at storage addresses NUM_BANKS*BANK_WORDS + s (s = 0 .. NUM_SLOTS-1) and are scanned from the highest s down; the first slot not equal to the erased value (all ones) selects the bank whose number it holds, and bank b word w sits at address b*BANK_WORDS + w.
- R5: When every slot reads as the erased value, bank 0 is loaded.
- R6: A programmed slot whose value is not below NUM_BANKS ends the sequence with done and load_err high, out_en low and no working-register writes.
- R7: A bank whose words sum to zero modulo 2^WORD_W is committed as exactly BANK_WORDS writes to addresses 0, 1, ... in ascending order carrying the bank's words, never in a cycle with a storage read, after which done and out_en rise with load_err low.
- R8: A bank whose sum is not zero produces no working-register write at all; done and load_err rise and out_en stays low.
- R9: Asserting reset mid-sequence aborts it with no commit, and the next release reruns the full sequence against the current storage contents.
- R10: Once done is high it, out_en and load_err hold until reset, and no further storage read or register write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Supply-valid reset, active low, asynchronous assert |
| instant_on | input | 1 | Skip the settling delay |
| nv_rd_en | output | 1 | Storage read request |
| nv_rd_addr | output | NV_AW | Storage word address |
| nv_rd_data | input | WORD_W | Storage data, valid one cycle after the request |
| wr_en | output | 1 | Working register write strobe |
| wr_addr | output | WORD_IW | Working register index |
| wr_data | output | WORD_W | Working register data |
| out_en | output | 1 | Conditioned output enable |
| done | output | 1 | Boot sequence finished |
| load_err | output | 1 | Boot failed (bad slot value or checksum) |

## Verification
The first storage read is due on a fixed edge after reset release, SETTLE_CYCLES edges normally and one edge under instant-on, so the bench counts edges from release and records the edge on which nv_rd_en is first seen, sampling on the falling clock. Slot scanning, bank reading and committing each take a data-dependent number of two-cycle or one-cycle steps, so the bench does not predict the done edge; it logs every write as it appears and judges the order, count and data once done is seen. The hold behaviour after done is checked over several further falling edges.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

   typedef enum logic [2:0] {
      ST_SETTLE   = 3'd0,
      ST_SLOT_REQ = 3'd1,
      ST_SLOT_CHK = 3'd2,
      ST_BANK_REQ = 3'd3,
      ST_BANK_CAP = 3'd4,
      ST_VERIFY   = 3'd5,
      ST_COMMIT   = 3'd6,
      ST_FINISH   = 3'd7
   } cbl_state_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/cbl_settle_timer.sv
module cbl_settle_timer #(
   parameter int unsigned LIMIT = 2500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic skip,
   output logic expired
);
   generate
      if (LIMIT <= 1) begin : g_none
         assign expired = 1'b1;
      end else begin : g_count
         localparam int unsigned CW = $clog2(LIMIT + 1);
         localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
         logic [CW-1:0] cnt;

         assign expired = skip || (cnt == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (run && !expired) begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cbl_csum_acc.sv
module cbl_csum_acc #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         add,
   input  logic [W-1:0] din,
   output logic         is_zero
);
   logic [W-1:0] sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum <= '0;
      end else if (clr) begin
         sum <= '0;
      end else if (add) begin
         sum <= sum + din;
      end
   end

   assign is_zero = (sum == '0);
endmodule

// File: rtl/cbl_stage_buf.sv
module cbl_stage_buf #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 8,
   parameter int unsigned IW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [W-1:0]  wr_data,
   input  logic [IW-1:0] rd_idx,
   output logic [W-1:0]  rd_data
);
   logic [W-1:0] rd_vec [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_word
         logic [W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (wr_en && (wr_idx == IW'(i))) begin
               q <= wr_data;
            end
         end
         assign rd_vec[i] = q;
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int j = 0; j < DEPTH; j++) begin
         if (rd_idx == IW'(j)) rd_data = rd_vec[j];
      end
   end
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
   import cbl_pkg::*;
#(
   parameter int unsigned WORD_W        = 8,
   parameter int unsigned BANK_WORDS    = 8,
   parameter int unsigned NUM_BANKS     = 7,
   parameter int unsigned NUM_SLOTS     = 4,
   parameter int unsigned SETTLE_CYCLES = 2500000,
   parameter logic [WORD_W-1:0] ERASED_VAL = '1,
   localparam int unsigned NV_DEPTH = NUM_BANKS * BANK_WORDS + NUM_SLOTS,
   localparam int unsigned NV_AW    = idx_width(NV_DEPTH),
   localparam int unsigned WORD_IW  = idx_width(BANK_WORDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instant_on,
   output logic               nv_rd_en,
   output logic [NV_AW-1:0]   nv_rd_addr,
   input  logic [WORD_W-1:0]  nv_rd_data,
   output logic               wr_en,
   output logic [WORD_IW-1:0] wr_addr,
   output logic [WORD_W-1:0]  wr_data,
   output logic               out_en,
   output logic               done,
   output logic               load_err
);
   localparam int unsigned SLOT_IW = idx_width(NUM_SLOTS);
   localparam int unsigned BANK_IW = idx_width(NUM_BANKS);
   localparam logic [NV_AW-1:0]   SLOT_BASE  = NV_AW'(NUM_BANKS * BANK_WORDS);
   localparam logic [SLOT_IW-1:0] SLOT_TOP   = SLOT_IW'(NUM_SLOTS - 1);
   localparam logic [WORD_IW-1:0] WORD_LAST  = WORD_IW'(BANK_WORDS - 1);
   localparam logic [WORD_W-1:0]  BANK_LIMIT = WORD_W'(NUM_BANKS);

   // elaboration-time parameter checks
   generate
      if (WORD_W < 2 || WORD_W > 32) begin : g_bad_word
         $error("cfg_boot_loader: WORD_W out of range");
      end
      if (NUM_BANKS < 1 || NUM_BANKS >= (1 << WORD_W)) begin : g_bad_banks
         $error("cfg_boot_loader: NUM_BANKS must fit in one word");
      end
      if (NUM_SLOTS < 1 || BANK_WORDS < 1) begin : g_bad_sizes
         $error("cfg_boot_loader: slot and bank sizes must be nonzero");
      end
      if (ERASED_VAL < BANK_LIMIT) begin : g_bad_erased
         $error("cfg_boot_loader: erased value collides with a bank number");
      end
   endgenerate

   cbl_state_e           state;
   logic [SLOT_IW-1:0]   slot_idx;
   logic [BANK_IW-1:0]   bank_q;
   logic [WORD_IW-1:0]   word_idx;
   logic                 out_en_q;
   logic                 done_q;
   logic                 err_q;

   logic                 settle_done;
   logic                 csum_zero;
   logic                 csum_clr;
   logic                 cap_en;
   logic [WORD_W-1:0]    stage_rd;
   logic                 slot_programmed;
   logic                 slot_in_range;

   cbl_settle_timer #(
      .LIMIT (SETTLE_CYCLES)
   ) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state == ST_SETTLE),
      .skip    (instant_on),
      .expired (settle_done)
   );

   assign csum_clr = (state == ST_SETTLE) || (state == ST_SLOT_CHK);
   assign cap_en   = (state == ST_BANK_CAP);

   cbl_csum_acc #(
      .W (WORD_W)
   ) u_csum (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (csum_clr),
      .add     (cap_en),
      .din     (nv_rd_data),
      .is_zero (csum_zero)
   );

   cbl_stage_buf #(
      .W     (WORD_W),
      .DEPTH (BANK_WORDS),
      .IW    (WORD_IW)
   ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cap_en),
      .wr_idx  (word_idx),
      .wr_data (nv_rd_data),
      .rd_idx  (word_idx),
      .rd_data (stage_rd)
   );

   assign slot_programmed = (nv_rd_data != ERASED_VAL);
   assign slot_in_range   = (nv_rd_data < BANK_LIMIT);

   // storage read port
   always_comb begin
      nv_rd_en   = (state == ST_SLOT_REQ) || (state == ST_BANK_REQ);
      if (state == ST_SLOT_REQ) begin
         nv_rd_addr = SLOT_BASE + NV_AW'(slot_idx);
      end else begin
         nv_rd_addr = NV_AW'(bank_q) * NV_AW'(BANK_WORDS) + NV_AW'(word_idx);
      end
   end

   // working register write port
   assign wr_en    = (state == ST_COMMIT);
   assign wr_addr  = word_idx;
   assign wr_data  = stage_rd;
   assign out_en   = out_en_q;
   assign done     = done_q;
   assign load_err = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_SETTLE;
         slot_idx <= SLOT_TOP;
         bank_q   <= '0;
         word_idx <= '0;
         out_en_q <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         unique case (state)
            ST_SETTLE: begin
               if (settle_done) begin
                  state    <= ST_SLOT_REQ;
                  slot_idx <= SLOT_TOP;
               end
            end
            ST_SLOT_REQ: begin
               state <= ST_SLOT_CHK;
            end
            ST_SLOT_CHK: begin
               if (slot_programmed) begin
                  if (slot_in_range) begin
                     bank_q   <= nv_rd_data[BANK_IW-1:0];
                     word_idx <= '0;
                     state    <= ST_BANK_REQ;
                  end else begin
                     err_q  <= 1'b1;
                     done_q <= 1'b1;
                     state  <= ST_FINISH;
                  end
               end else if (slot_idx == '0) begin
                  bank_q   <= '0;
                  word_idx <= '0;
                  state    <= ST_BANK_REQ;
               end else begin
                  slot_idx <= slot_idx - 1'b1;
                  state    <= ST_SLOT_REQ;
               end
            end
            ST_BANK_REQ: begin
               state <= ST_BANK_CAP;
            end
            ST_BANK_CAP: begin
               if (word_idx == WORD_LAST) begin
                  state <= ST_VERIFY;
               end else begin
                  word_idx <= word_idx + 1'b1;
                  state    <= ST_BANK_REQ;
               end
            end
            ST_VERIFY: begin
               word_idx <= '0;
               if (csum_zero) begin
                  state <= ST_COMMIT;
               end else begin
                  err_q  <= 1'b1;
                  done_q <= 1'b1;
                  state  <= ST_FINISH;
               end
            end
            ST_COMMIT: begin
               if (word_idx == WORD_LAST) begin
                  out_en_q <= 1'b1;
                  done_q   <= 1'b1;
                  state    <= ST_FINISH;
               end else begin
                  word_idx <= word_idx + 1'b1;
               end
            end
            ST_FINISH: begin
               state <= ST_FINISH;
            end
            default: state <= ST_FINISH;
         endcase
      end
   end
endmodule

// File: rtl/cbl_boot_loader_chk.sv
module cbl_boot_loader_chk #(
   parameter int unsigned BANK_WORDS    = 8,
   parameter int unsigned SETTLE_CYCLES = 2500000
) (
   input logic clk,
   input logic rst_n,
   input logic instant_on,
   input logic nv_rd_en,
   input logic wr_en,
   input logic out_en,
   input logic done,
   input logic load_err
);
   localparam int unsigned CW = $clog2(SETTLE_CYCLES + 2);
   localparam int unsigned WW = $clog2(BANK_WORDS + 2);
   localparam logic [CW-1:0] SAT = CW'(SETTLE_CYCLES);

   logic [CW-1:0] since_rst;
   logic [WW-1:0] wr_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rst <= '0;
         wr_cnt    <= '0;
      end else begin
         if (since_rst != SAT) since_rst <= since_rst + 1'b1;
         if (wr_en) wr_cnt <= wr_cnt + 1'b1;
      end
   end

   // R2: no storage read inside the settling window
   p_no_early_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_rd_en && !instant_on) |-> (since_rst == SAT));

   // R7: a successful boot wrote exactly one bank
   p_commit_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !load_err) |-> (wr_cnt == WW'(BANK_WORDS)));

   // R7: writes never overlap storage reads
   p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      nv_rd_en |-> !wr_en);

   // R8: a failed boot wrote nothing
   p_err_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load_err |-> (wr_cnt == '0));

   // R8: output only after a clean finish
   p_out_needs_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_en |-> (done && !load_err));

   // R10: finished state is sticky
   p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && $stable(out_en) && $stable(load_err)));

   // R10: bus quiet after finish
   p_quiet_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!nv_rd_en && !wr_en));
endmodule

bind cfg_boot_loader cbl_boot_loader_chk #(
   .BANK_WORDS    (BANK_WORDS),
   .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .instant_on (instant_on),
   .nv_rd_en   (nv_rd_en),
   .wr_en      (wr_en),
   .out_en     (out_en),
   .done       (done),
   .load_err   (load_err)
);

// File: tb/tb_cfg_boot_loader.sv
`timescale 1ns/1ps
module tb_cfg_boot_loader;
   localparam int S   = 20;
   localparam int NB  = 7;
   localparam int BW  = 8;
   localparam int NS  = 4;
   localparam int NV  = NB * BW + NS;
   localparam int SB  = NB * BW;
   localparam int AW  = $clog2(NV);
   localparam int IW  = $clog2(BW);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          instant_on = 1'b0;
   logic          nv_rd_en;
   logic [AW-1:0] nv_rd_addr;
   logic [7:0]    nv_rd_data;
   logic          wr_en;
   logic [IW-1:0] wr_addr;
   logic [7:0]    wr_data;
   logic          out_en;
   logic          done;
   logic          load_err;

   logic [7:0] mem [NV];

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int first_rd = -1;
   int wcount = 0;
   bit order_bad = 0;
   bit early_oe = 0;
   logic [7:0] wlog [BW];
   bit finished = 0;

   cfg_boot_loader #(
      .WORD_W        (8),
      .BANK_WORDS    (BW),
      .NUM_BANKS     (NB),
      .NUM_SLOTS     (NS),
      .SETTLE_CYCLES (S)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .instant_on (instant_on),
      .nv_rd_en   (nv_rd_en),
      .nv_rd_addr (nv_rd_addr),
      .nv_rd_data (nv_rd_data),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .out_en     (out_en),
      .done       (done),
      .load_err   (load_err)
   );

   always #4 clk = ~clk;

   always_ff @(posedge clk) begin
      if (nv_rd_en) nv_rd_data <= (int'(nv_rd_addr) < NV) ? mem[nv_rd_addr] : 8'h00;
   end

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else cyc <= cyc + 1;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (nv_rd_en && first_rd < 0) first_rd = cyc;
         if (wr_en) begin
            if (int'(wr_addr) != wcount) order_bad = 1;
            if (int'(wr_addr) < BW) wlog[wr_addr] = wr_data;
            wcount++;
         end
         if (out_en && !done) early_oe = 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_bank();
      for (int s = NS - 1; s >= 0; s--) begin
         if (mem[SB + s] != 8'hFF) return int'(mem[SB + s]);
      end
      return 0;
   endfunction

   function automatic bit all_erased();
      for (int s = 0; s < NS; s++) if (mem[SB + s] != 8'hFF) return 0;
      return 1;
   endfunction

   function automatic logic [7:0] bank_sum(input int b);
      logic [7:0] acc = 8'h00;
      for (int w = 0; w < BW; w++) acc = acc + mem[b * BW + w];
      return acc;
   endfunction

   task automatic fix_bank(input int b);
      logic [7:0] acc = 8'h00;
      for (int w = 0; w < BW - 1; w++) acc = acc + mem[b * BW + w];
      mem[b * BW + BW - 1] = 8'h00 - acc;
   endtask

   task automatic fill_random(input bit all_good);
      for (int b = 0; b < NB; b++) begin
         for (int w = 0; w < BW; w++) mem[b * BW + w] = 8'($urandom);
         if (all_good || ($urandom % 4) != 0) fix_bank(b);
      end
      for (int s = 0; s < NS; s++) begin
         int r = int'($urandom % 8);
         if (r < 4) mem[SB + s] = 8'hFF;
         else if (r < 7) mem[SB + s] = 8'($urandom % NB);
         else mem[SB + s] = 8'(NB + ($urandom % (255 - NB)));
      end
   endtask

   task automatic run_boot(input bit inst);
      int eb;
      bit ebad;
      bit quiet;
      int mism;
      string rq;
      instant_on = inst;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1: quiet while reset is held
      check(!out_en && !done && !load_err && !wr_en && !nv_rd_en, "R1",
            {out_en, done, load_err, wr_en, nv_rd_en}, 0);
      first_rd = -1;
      wcount = 0;
      order_bad = 0;
      early_oe = 0;
      for (int w = 0; w < BW; w++) wlog[w] = 8'h00;
      rst_n = 1'b1;
      @(negedge clk);
      // R1: still quiet one edge after release
      check(!out_en && !done && !load_err && !wr_en, "R1",
            {out_en, done, load_err, wr_en}, 0);
      for (int i = 0; i < 1000 && !done; i++) @(negedge clk);
      check(done, "R10", done, 1);
      eb = exp_bank();
      ebad = (eb >= NB) ? 1'b1 : (bank_sum(eb) != 8'h00);
      check(first_rd == (inst ? 1 : S), inst ? "R3" : "R2", first_rd, inst ? 1 : S);
      check(!early_oe, "R2", early_oe, 0);
      if (eb >= NB) begin
         check(load_err && !out_en && wcount == 0, "R6", {load_err, out_en, 8'(wcount)}, 10'h200);
      end else if (ebad) begin
         check(load_err && !out_en && wcount == 0, "R8", {load_err, out_en, 8'(wcount)}, 10'h200);
      end else begin
         rq = all_erased() ? "R5" : "R4";
         check(!load_err && out_en, "R7", {load_err, out_en}, 1);
         check(wcount == BW && !order_bad, "R7", wcount, BW);
         mism = 0;
         for (int w = 0; w < BW; w++) if (wlog[w] != mem[eb * BW + w]) mism++;
         check(mism == 0, rq, mism, 0);
      end
      quiet = 1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (nv_rd_en || wr_en || !done) quiet = 0;
      end
      check(quiet, "R10", quiet, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      fill_random(1'b1);

      // R5: all slots erased -> bank 0
      for (int s = 0; s < NS; s++) mem[SB + s] = 8'hFF;
      run_boot(1'b0);

      // R4: only lowest slot programmed
      mem[SB + 0] = 8'd3;
      run_boot(1'b0);

      // R4: highest slot wins over lower ones
      mem[SB + 1] = 8'd2; mem[SB + 2] = 8'd5; mem[SB + 3] = 8'd6;
      run_boot(1'b0);

      // R3: instant-on path
      run_boot(1'b1);

      // R6: out-of-range slot value
      mem[SB + 3] = 8'd7;
      run_boot(1'b0);

      // R8: corrupt the selected bank
      mem[SB + 3] = 8'd4;
      fix_bank(4);
      mem[4 * BW + 2] = mem[4 * BW + 2] + 8'd1;
      run_boot(1'b0);

      // R9: abort mid-read, then rerun with new contents
      fix_bank(4);
      instant_on = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      wcount = 0;
      rst_n = 1'b1;
      repeat (S + 12) @(negedge clk);
      check(!out_en && !done && wcount == 0, "R9", {out_en, done, 8'(wcount)}, 0);
      mem[SB + 3] = 8'd1;
      run_boot(1'b0);

      // random mix
      for (int t = 0; t < 40; t++) begin
         fill_random(1'b0);
         run_boot(($urandom % 4) == 0);
      end

      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule